// File: doc/BRIEF.md
# Validated Serial Configuration Loader

This block receives 72-bit configuration words over a three-wire serial port. The port has a data line, a bit clock and a strobe. It decides whether each word is meant for this device and whether it arrived intact. A word that passes is parked in a shadow register and routed to one of two register banks: a control bank or an adjustment bank. Words that fail, and words sent at a time when they may not be taken, are thrown away and counted.

The bank registers do not change when the strobe arrives. A parked word is copied into its bank on the falling edge of the line-sync input, and only while the readout-line input is high. At most one such copy happens per vertical interval; a rising edge of frame-sync opens the next interval. Two fields of an accepted control word skip that wait and take effect at once on the strobe: the two power-mode bits and the sync-generator enable bit. The serial inputs are assumed to be synchronous to `clk` and slow enough that every serial-clock level lasts at least one `clk` cycle.

Top module: `scl_cfg_loader`

## Requirements
- R1: While `rst_n` is low at a clock edge, both banks, `power_mode`, `sync_en`, `pending` and `dropped` are cleared to zero.
- R2: While the strobe is low, a bit is sampled on each rising edge of the serial clock, with frame bit D00 first. A frame ends on the strobe's rising edge. If exactly 72 bits have been received at that point, the frame is examined; any other count discards it.
- R3: A frame is taken only if its byte D07..D00 equals 8'h81. A frame with any other value in that byte is discarded.
- R4: While `csum_bypass` is low, the nine bytes D07..D00, D15..D08, and so on up to D71..D64 must add up to 0 modulo 256, or the frame is discarded. While `csum_bypass` is high, this sum is not checked.
- R5: Bit D08 selects the target bank: 0 selects the control bank and 1 selects the adjustment bank. Bit i of the target bank receives frame bit D(16+i), for i from 0 to 55.
- R6: A taken frame raises `pending`, and the banks stay unchanged at the strobe. The parked word is written on the first falling edge of `line_sync` that occurs while `readout_line` is high. At that point `pending` drops. A falling edge of `line_sync` while `readout_line` is low has no effect.
- R7: A taken control-bank frame updates `power_mode` from D63..D62 and `sync_en` from D52, one cycle after the strobe edge and without waiting for a commit. A frame for the adjustment bank leaves both outputs unchanged.
- R8: After a commit, neither bank is written again until a rising edge of `frame_sync` has been seen.
- R9: If a new frame arrives for the same bank as the parked word, it replaces the parked word. If a new frame arrives for the other bank while a word is still parked, the new frame is discarded.
- R10: A frame whose strobe edge comes while `shutter_busy` is high is discarded. Its immediate fields are not applied either.
- R11: `dropped` rises by one for each discarded frame and holds at its all-ones value once it gets there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_data | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial bit clock; data is sampled on its rising edge |
| ser_strobe | input | 1 | Frame strobe; low while bits are shifted in, and its rising edge ends the frame |
| csum_bypass | input | 1 | High skips the checksum test |
| shutter_busy | input | 1 | High while a multi-frame shutter interval is running; frames are refused |
| line_sync | input | 1 | Line sync; its falling edge is the commit point |
| readout_line | input | 1 | High during the readout line |
| frame_sync | input | 1 | Vertical sync; its rising edge opens a new commit interval |
| ctrl_bank | output | 56 | Committed control bank (frame bits D71..D16) |
| adj_bank | output | 56 | Committed adjustment bank (frame bits D71..D16) |
| power_mode | output | 2 | Power-mode field, applied immediately |
| sync_en | output | 1 | Sync-generator enable, applied immediately |
| pending | output | 1 | A taken word is waiting for its commit |
| dropped | output | DROP_W | Saturating count of discarded frames |

## Verification
The bench sends frames of 71 and 73 bits. A loader that checked the count loosely would take one of them, and a loader that shifted MSB first would commit a payload that is bit-reversed. It also sends a frame with a wrong checksum, first with the bypass off and then with it on, and a frame with a chip byte that differs in only one bit. A design that summed only eight bytes, or that tested only D00 and D07, would let one of these through.

Commits are probed at several points. A line-sync fall outside the readout line must not commit. A second line-sync fall inside the same vertical interval must not commit either. Two words are sent for the same bank, and the second must win; a word sent for the other bank while one is parked must be refused. A design that committed on the strobe, or allowed a second commit per interval, would show a changed bank where none is expected. The immediate fields are checked both before any commit and under a busy shutter. A sweep over sixteen payloads that alternate between the banks covers every power-mode value. Finally, a long run of empty frames drives the drop counter into saturation.

// File: rtl/scl_pkg.sv
// Package: shared constants and types of the serial configuration loader.
// Assumes an LSB-first frame of whole bytes.
package scl_pkg;
    localparam int FRAME_BITS   = 72;
    localparam int BYTE_W       = 8;
    localparam int NUM_BYTES    = FRAME_BITS / BYTE_W;
    localparam int PAYLOAD_LSB  = 16;
    localparam int BANK_W       = FRAME_BITS - PAYLOAD_LSB;
    localparam int CNT_W        = $clog2(FRAME_BITS + 2);
    localparam logic [BYTE_W-1:0] CHIP_CODE = 8'h81;
    localparam int BANK_SEL_BIT = 8;
    localparam int PWR_HI       = 63;
    localparam int SYNC_BIT     = 52;
    localparam int PWR_W        = 2;

    typedef enum logic {
        BANK_CTRL = 1'b0,
        BANK_ADJ  = 1'b1
    } bank_e;
endpackage

// File: rtl/scl_shifter.sv
// Module: serial front end. Shifts bits in LSB first on rising edges of the
// serial clock while the strobe is low, and counts them with saturation.
// It flags whether exactly FRAME_BITS bits were seen when the strobe rises.
// Assumes the serial pins are already synchronous to clk.
module scl_shifter
    import scl_pkg::*;
#(
    parameter int FB = FRAME_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ser_data,
    input  logic          ser_clk,
    input  logic          ser_strobe,
    output logic [FB-1:0] frame_word,
    output logic          frame_len_ok,
    output logic          frame_strobe
);
    localparam int CW = $clog2(FB + 2);
    localparam logic [CW-1:0] FULL_CNT = CW'(FB);
    localparam logic [CW-1:0] SAT_CNT  = CW'(FB + 1);

    logic          sclk_q;
    logic          stb_q;
    logic [FB-1:0] shreg;
    logic [CW-1:0] bit_cnt;
    logic          sclk_rise;

    assign sclk_rise    = ser_clk & ~sclk_q;
    assign frame_strobe = ser_strobe & ~stb_q;
    assign frame_len_ok = (bit_cnt == FULL_CNT);
    assign frame_word   = shreg;

    // Edge history; the strobe idles high, so it resets high and gives no false edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            stb_q  <= 1'b1;
        end else begin
            sclk_q <= ser_clk;
            stb_q  <= ser_strobe;
        end
    end

    // Shift register and saturating bit counter; a strobe edge starts a new count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (frame_strobe) begin
            bit_cnt <= '0;
        end else if (sclk_rise && !ser_strobe) begin
            shreg   <= {ser_data, shreg[FB-1:1]};
            bit_cnt <= (bit_cnt == SAT_CNT) ? bit_cnt : bit_cnt + 1'b1;
        end
    end

    // R2: the counter never passes its saturation value.
    a_r2_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= SAT_CNT);
endmodule

// File: rtl/scl_validator.sv
// Module: combinational test of a finished frame. It checks the chip byte and
// the modulo-256 byte sum (unless bypassed), then splits out the bank select,
// the payload and the fields that are applied at once.
module scl_validator
    import scl_pkg::*;
(
    input  logic [FRAME_BITS-1:0] frame_word,
    input  logic                  frame_len_ok,
    input  logic                  csum_bypass,
    output logic                  word_ok,
    output bank_e                 word_bank,
    output logic [BANK_W-1:0]     word_payload,
    output logic [PWR_W-1:0]      word_pwr,
    output logic                  word_sync
);
    logic [BYTE_W-1:0] part_sum [NUM_BYTES+1];
    logic              id_ok;
    logic              sum_ok;

    assign part_sum[0] = '0;
    // One adder stage per frame byte builds the running sum.
    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_sum
        assign part_sum[g+1] = part_sum[g] + frame_word[g*BYTE_W +: BYTE_W];
    end

    assign id_ok        = (frame_word[BYTE_W-1:0] == CHIP_CODE);
    assign sum_ok       = csum_bypass | (part_sum[NUM_BYTES] == '0);
    assign word_ok      = frame_len_ok & id_ok & sum_ok;
    assign word_bank    = bank_e'(frame_word[BANK_SEL_BIT]);
    assign word_payload = frame_word[FRAME_BITS-1:PAYLOAD_LSB];
    assign word_pwr     = frame_word[PWR_HI -: PWR_W];
    assign word_sync    = frame_word[SYNC_BIT];
endmodule

// File: rtl/scl_commit.sv
// Module: shadow register and commit control. It parks a taken word, writes
// it to its bank on a line-sync fall during the readout line (once per
// vertical interval), applies the power and sync fields at the strobe, and
// counts discarded frames. Assumes frame_strobe is a one-cycle pulse.
module scl_commit
    import scl_pkg::*;
#(
    parameter int DROP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_strobe,
    input  logic              word_ok,
    input  bank_e             word_bank,
    input  logic [BANK_W-1:0] word_payload,
    input  logic [PWR_W-1:0]  word_pwr,
    input  logic              word_sync,
    input  logic              shutter_busy,
    input  logic              line_sync,
    input  logic              readout_line,
    input  logic              frame_sync,
    output logic [BANK_W-1:0] ctrl_bank,
    output logic [BANK_W-1:0] adj_bank,
    output logic [PWR_W-1:0]  power_mode,
    output logic              sync_en,
    output logic              pending,
    output logic [DROP_W-1:0] dropped
);
    logic              hs_q, fs_q;
    logic              line_fall, fs_rise;
    logic [BANK_W-1:0] shadow_q;
    bank_e             pend_bank_q;
    logic              pend_q, done_q;
    logic              commit_now, pend_left, conflict, take, drop;
    logic [BANK_W-1:0] ctrl_q, adj_q;
    logic [PWR_W-1:0]  pwr_q;
    logic              sync_q;
    logic [DROP_W-1:0] drop_q;

    assign line_fall  = hs_q & ~line_sync;
    assign fs_rise    = frame_sync & ~fs_q;
    assign commit_now = pend_q & line_fall & readout_line & ~done_q;
    assign pend_left  = pend_q & ~commit_now;
    assign conflict   = pend_left & (word_bank != pend_bank_q);
    assign take       = frame_strobe & word_ok & ~shutter_busy & ~conflict;
    assign drop       = frame_strobe & ~take;

    // Sync edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q <= 1'b0;
            fs_q <= 1'b0;
        end else begin
            hs_q <= line_sync;
            fs_q <= frame_sync;
        end
    end

    // Shadow register: holds the latest taken word and its bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q    <= '0;
            pend_bank_q <= BANK_CTRL;
        end else if (take) begin
            shadow_q    <= word_payload;
            pend_bank_q <= word_bank;
        end
    end

    // Pending flag: set by a take, cleared by a commit.
    always_ff @(posedge clk) begin
        if (!rst_n)          pend_q <= 1'b0;
        else if (take)       pend_q <= 1'b1;
        else if (commit_now) pend_q <= 1'b0;
    end

    // Interval flag: a commit closes the vertical interval until frame_sync rises.
    always_ff @(posedge clk) begin
        if (!rst_n)          done_q <= 1'b0;
        else if (commit_now) done_q <= 1'b1;
        else if (fs_rise)    done_q <= 1'b0;
    end

    // Bank registers: written only at a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            adj_q  <= '0;
        end else if (commit_now) begin
            if (pend_bank_q == BANK_CTRL) ctrl_q <= shadow_q;
            else                          adj_q  <= shadow_q;
        end
    end

    // Immediate fields: applied when a control word is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_q  <= '0;
            sync_q <= 1'b0;
        end else if (take && word_bank == BANK_CTRL) begin
            pwr_q  <= word_pwr;
            sync_q <= word_sync;
        end
    end

    // Drop counter: saturating count of refused frames.
    always_ff @(posedge clk) begin
        if (!rst_n)                      drop_q <= '0;
        else if (drop && drop_q != '1)   drop_q <= drop_q + 1'b1;
    end

    assign ctrl_bank  = ctrl_q;
    assign adj_bank   = adj_q;
    assign power_mode = pwr_q;
    assign sync_en    = sync_q;
    assign pending    = pend_q;
    assign dropped    = drop_q;

    // R6: banks change only after a line-sync fall inside the readout line.
    a_r6_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_fall && readout_line) |=> ($stable(ctrl_q) && $stable(adj_q)));
    // R8: once the interval is used, banks hold until frame_sync rises.
    a_r8_one_per_interval: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !fs_rise) |=> ($stable(ctrl_q) && $stable(adj_q)));
    // R7: immediate fields move only on a strobe edge.
    a_r7_power_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_strobe |=> ($stable(pwr_q) && $stable(sync_q)));
    // R11: the drop counter holds or steps by exactly one.
    a_r11_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((drop_q == $past(drop_q)) || (drop_q == $past(drop_q) + 1'b1)));
endmodule

// File: rtl/scl_cfg_loader.sv
// Module: top of the validated serial configuration loader. It joins the
// serial front end, the frame validator and the commit controller.
// Assumes the serial and sync inputs are synchronous to clk.
module scl_cfg_loader
    import scl_pkg::*;
#(
    parameter int DROP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_data,
    input  logic              ser_clk,
    input  logic              ser_strobe,
    input  logic              csum_bypass,
    input  logic              shutter_busy,
    input  logic              line_sync,
    input  logic              readout_line,
    input  logic              frame_sync,
    output logic [55:0]       ctrl_bank,
    output logic [55:0]       adj_bank,
    output logic [1:0]        power_mode,
    output logic              sync_en,
    output logic              pending,
    output logic [DROP_W-1:0] dropped
);
    logic [FRAME_BITS-1:0] frame_word;
    logic                  frame_len_ok, frame_strobe;
    logic                  word_ok, word_sync;
    bank_e                 word_bank;
    logic [BANK_W-1:0]     word_payload;
    logic [PWR_W-1:0]      word_pwr;

    scl_shifter #(.FB(FRAME_BITS)) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .ser_data     (ser_data),
        .ser_clk      (ser_clk),
        .ser_strobe   (ser_strobe),
        .frame_word   (frame_word),
        .frame_len_ok (frame_len_ok),
        .frame_strobe (frame_strobe)
    );

    scl_validator u_check (
        .frame_word   (frame_word),
        .frame_len_ok (frame_len_ok),
        .csum_bypass  (csum_bypass),
        .word_ok      (word_ok),
        .word_bank    (word_bank),
        .word_payload (word_payload),
        .word_pwr     (word_pwr),
        .word_sync    (word_sync)
    );

    scl_commit #(.DROP_W(DROP_W)) u_commit (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_strobe (frame_strobe),
        .word_ok      (word_ok),
        .word_bank    (word_bank),
        .word_payload (word_payload),
        .word_pwr     (word_pwr),
        .word_sync    (word_sync),
        .shutter_busy (shutter_busy),
        .line_sync    (line_sync),
        .readout_line (readout_line),
        .frame_sync   (frame_sync),
        .ctrl_bank    (ctrl_bank),
        .adj_bank     (adj_bank),
        .power_mode   (power_mode),
        .sync_en      (sync_en),
        .pending      (pending),
        .dropped      (dropped)
    );
endmodule

// File: tb/scl_cfg_loader_test.sv
module scl_cfg_loader_test;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, ser_data, ser_clk, ser_strobe, csum_bypass, shutter_busy;
    logic        line_sync, readout_line, frame_sync;
    logic [55:0] ctrl_bank, adj_bank;
    logic [1:0]  power_mode;
    logic        sync_en, pending;
    logic [7:0]  dropped;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int exp_drop = 0;

    scl_cfg_loader #(.DROP_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
        .ser_strobe(ser_strobe), .csum_bypass(csum_bypass), .shutter_busy(shutter_busy),
        .line_sync(line_sync), .readout_line(readout_line), .frame_sync(frame_sync),
        .ctrl_bank(ctrl_bank), .adj_bank(adj_bank), .power_mode(power_mode),
        .sync_en(sync_en), .pending(pending), .dropped(dropped)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // Frame with a given chip byte, bank bit and body D63..D16; the checksum byte makes the sum zero.
    function automatic logic [71:0] build(input logic [7:0] id, input bit bank,
                                          input logic [47:0] body);
        logic [71:0] d;
        logic [7:0]  s;
        d = '0;
        d[7:0]   = id;
        d[8]     = bank;
        d[63:16] = body;
        s = '0;
        for (int b = 0; b < 8; b++) s = s + d[b*8 +: 8];
        d[71:64] = 8'(0) - s;
        return d;
    endfunction

    function automatic logic [47:0] body_of(input logic [1:0] pm, input bit sy,
                                            input logic [47:0] base);
        logic [47:0] b;
        b = base;
        b[47:46] = pm;   // D63..D62
        b[36]    = sy;   // D52
        return b;
    endfunction

    task automatic send(input logic [71:0] d, input int nbits);
        @(negedge clk) ser_strobe = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            ser_data = (i < 72) ? d[i] : 1'b1;
            ser_clk  = 1'b0;
            @(negedge clk) ser_clk = 1'b1;
            @(negedge clk) ser_clk = 1'b0;
        end
        @(negedge clk) ser_strobe = 1'b1;
        @(negedge clk);
    endtask

    task automatic line_pulse(input bit ro);
        @(negedge clk) begin readout_line = ro; line_sync = 1'b1; end
        @(negedge clk) line_sync = 1'b0;
        @(negedge clk) readout_line = 1'b0;
    endtask

    task automatic vpulse;
        @(negedge clk) frame_sync = 1'b1;
        @(negedge clk) frame_sync = 1'b0;
    endtask

    task automatic do_reset;
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        exp_drop = 0;
    endtask

    task automatic check_zero(input string tag);
        check(ctrl_bank == 0, tag, "ctrl_bank after reset", 64'(ctrl_bank), 0);
        check(adj_bank == 0, tag, "adj_bank after reset", 64'(adj_bank), 0);
        check(power_mode == 0 && sync_en == 0, tag, "immediate fields after reset",
              64'({power_mode, sync_en}), 0);
        check(pending == 0, tag, "pending after reset", 64'(pending), 0);
        check(dropped == 0, tag, "dropped after reset", 64'(dropped), 0);
    endtask

    task automatic expect_drop(input string tag);
        exp_drop = (exp_drop < 255) ? exp_drop + 1 : 255;
        check(dropped == 8'(exp_drop), tag, "dropped count", 64'(dropped), 64'(exp_drop));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [71:0] da, db, dc, d2, d3, d4;
        logic [55:0] exp_ctrl, exp_adj;
        logic [1:0]  exp_pm;
        bit          exp_sy;

        rst_n = 1'b0; ser_data = 1'b0; ser_clk = 1'b0; ser_strobe = 1'b1;
        csum_bypass = 1'b0; shutter_busy = 1'b0; line_sync = 1'b0;
        readout_line = 1'b0; frame_sync = 1'b0;
        do_reset();
        check_zero("R1");

        // R5 R6 R7: control word parks; immediate fields apply at once.
        da = build(8'h81, 1'b0, body_of(2'b10, 1'b1, 48'h1234_5678_9ABC));
        send(da, 72);
        check(pending == 1, "R6", "pending after strobe", 64'(pending), 1);
        check(ctrl_bank == 0, "R6", "ctrl unchanged at strobe", 64'(ctrl_bank), 0);
        check(power_mode == 2'b10, "R7", "power_mode immediate", 64'(power_mode), 2);
        check(sync_en == 1, "R7", "sync_en immediate", 64'(sync_en), 1);
        line_pulse(1'b0);
        check(ctrl_bank == 0 && pending == 1, "R6", "no commit outside readout",
              64'(ctrl_bank), 0);
        line_pulse(1'b1);
        check(ctrl_bank == da[71:16], "R5", "ctrl committed", 64'(ctrl_bank), 64'(da[71:16]));
        check(pending == 0, "R6", "pending cleared by commit", 64'(pending), 0);
        exp_ctrl = da[71:16];

        // R8: second commit in the same interval must wait for frame_sync.
        db = build(8'h81, 1'b1, 48'hA5A5_0F0F_3C3C);
        send(db, 72);
        line_pulse(1'b1);
        check(adj_bank == 0 && pending == 1, "R8", "no second commit in interval",
              64'(adj_bank), 0);
        vpulse();
        line_pulse(1'b1);
        check(adj_bank == db[71:16], "R8", "adj committed next interval",
              64'(adj_bank), 64'(db[71:16]));
        check(power_mode == 2'b10 && sync_en == 1, "R7", "adj word leaves immediate fields",
              64'({power_mode, sync_en}), 64'(5));
        exp_adj = db[71:16];

        // R3: one bit off in the chip byte.
        vpulse();
        send(build(8'h83, 1'b0, 48'h1111_2222_3333), 72);
        expect_drop("R3");
        check(pending == 0, "R3", "wrong id not parked", 64'(pending), 0);

        // R4: bad checksum, then the same frame with bypass.
        dc = build(8'h81, 1'b0, body_of(2'b01, 1'b0, 48'h0055_AA00_FF11));
        dc[64] = ~dc[64];
        send(dc, 72);
        expect_drop("R4");
        check(pending == 0, "R4", "bad sum not parked", 64'(pending), 0);
        csum_bypass = 1'b1;
        send(dc, 72);
        check(pending == 1 && dropped == 8'(exp_drop), "R4", "bypass accepts",
              64'({pending, dropped}), 64'({1'b1, 8'(exp_drop)}));
        check(power_mode == 2'b01, "R4", "bypass word applies power", 64'(power_mode), 1);
        line_pulse(1'b1);
        check(ctrl_bank == dc[71:16], "R4", "bypass word committed",
              64'(ctrl_bank), 64'(dc[71:16]));
        csum_bypass = 1'b0;
        exp_ctrl = dc[71:16];

        // R2: wrong lengths.
        vpulse();
        send(da, 71);
        expect_drop("R2");
        send(da, 73);
        expect_drop("R2");
        check(pending == 0, "R2", "wrong length not parked", 64'(pending), 0);

        // R10: busy shutter refuses the word.
        shutter_busy = 1'b1;
        send(build(8'h81, 1'b0, body_of(2'b11, 1'b1, 48'h0)), 72);
        expect_drop("R10");
        check(power_mode == 2'b01 && pending == 0, "R10", "busy leaves state",
              64'({power_mode, pending}), 64'(2));
        shutter_busy = 1'b0;

        // R9: same-bank overwrite, then other-bank refusal.
        d2 = build(8'h81, 1'b0, 48'h0BAD_F00D_0001);
        d3 = build(8'h81, 1'b0, 48'h0C0F_FEE0_0002);
        send(d2, 72);
        send(d3, 72);
        line_pulse(1'b1);
        check(ctrl_bank == d3[71:16], "R9", "later word wins",
              64'(ctrl_bank), 64'(d3[71:16]));
        vpulse();
        send(d2, 72);
        d4 = build(8'h81, 1'b1, 48'h7777_8888_9999);
        send(d4, 72);
        expect_drop("R9");
        line_pulse(1'b1);
        check(ctrl_bank == d2[71:16] && adj_bank == exp_adj, "R9",
              "other bank refused while parked", 64'(adj_bank), 64'(exp_adj));
        exp_pm = 2'b00;
        exp_sy = 1'b0;

        // R5 R7 sweep: alternating banks, all power values.
        for (int k = 0; k < 16; k++) begin
            logic [71:0] dk;
            logic [47:0] base;
            bit          bk;
            base = 48'(k * 48'h1F3A_5BC7_D9E1) ^ 48'h0123_4567_89AB;
            bk   = k[0];
            dk   = build(8'h81, bk, body_of(2'(k >> 1), k[2], base));
            vpulse();
            send(dk, 72);
            if (!bk) begin
                exp_pm = 2'(k >> 1);
                exp_sy = k[2];
            end
            check(power_mode == exp_pm && sync_en == exp_sy, "R7", "sweep immediate fields",
                  64'({power_mode, sync_en}), 64'({exp_pm, exp_sy}));
            line_pulse(1'b1);
            if (bk) exp_adj = dk[71:16];
            else    exp_ctrl = dk[71:16];
            check(ctrl_bank == exp_ctrl, "R5", "sweep ctrl bank", 64'(ctrl_bank), 64'(exp_ctrl));
            check(adj_bank == exp_adj, "R5", "sweep adj bank", 64'(adj_bank), 64'(exp_adj));
        end

        // R11: saturate the drop counter with empty frames.
        for (int n = 0; n < 300; n++) begin
            send(72'h0, 0);
            exp_drop = (exp_drop < 255) ? exp_drop + 1 : 255;
        end
        check(dropped == 8'd255, "R11", "drop counter saturates", 64'(dropped), 255);

        // R1: reset clears everything again.
        do_reset();
        check_zero("R1");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule